// File: doc/BRIEF.md
# Division Special-Case Operand Screener

This block inspects a pair of IEEE-754 double-precision operands, a dividend A and a divisor B, and decides whether a fast software divide sequence built on reciprocal estimates and refinement steps can run on them safely. Each operand is classified as zero, denormal, infinite, NaN or normal from its exponent and fraction fields alone. The unbiased exponents of A and B are then compared against fixed limits, and so is their difference. The outcome is three branch hints: an exception hint FE that routes software to a special-case handler, a guard hint FG, and an estimate-precision hint FL. FL is fixed when the chip is built.

The three hints are packed into a 4-bit condition field. A new operand pair may be presented on any cycle with `in_valid`. The field and its `out_valid` appear on the next rising clock edge. When no valid operand pair arrives, the field keeps its last value. The unbiased exponent is the 11-bit biased field minus 1023. A biased field of zero, which covers zero and denormals, counts as -1022. All exponent arithmetic is signed and wide enough that the difference of two exponents cannot wrap.

Top module: `div_screen`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` and `cond` both become 0 at that edge.
- R2: `out_valid` equals the `in_valid` of the previous rising edge. `cond` is updated only at an edge where `in_valid` is 1, and otherwise holds its value. Operand pairs may be presented back to back on consecutive cycles.
- R3: FE (`cond[1]`) is 1 when A is NaN or infinite, or when B is zero, NaN or infinite. Infinity is an all-ones exponent with a zero fraction. NaN, quiet or signaling, is an all-ones exponent with a nonzero fraction. Zero is a zero exponent with a zero fraction.
- R4: FE is 1 when the unbiased exponent of B is -1022 or below, or 1021 or above. A denormal B counts as -1022.
- R5: When A is nonzero, FE is 1 if the unbiased exponent of A minus that of B is 1023 or more, or -1021 or less. When A is zero, the difference has no effect.
- R6: When A is nonzero, FE is 1 if the unbiased exponent of A is -970 or below. A denormal A counts as -1022. When none of the conditions in R3 to R6 holds, FE is 0.
- R7: FG (`cond[2]`) is 1 when B is zero, infinite or denormal (a zero exponent with a nonzero fraction), or when A is infinite. Otherwise FG is 0.
- R8: `cond` is {FL, FG, FE, 0}: bit 3 is FL, bit 2 is FG, bit 1 is FE and bit 0 is always 0. FL equals the parameter `EST_PRECISE` (default 1) for every result.
- R9: The sign bits of A and B have no effect on `cond`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair on `opa`/`opb` is to be screened this cycle |
| opa | input | 64 | Dividend A, IEEE-754 double |
| opb | input | 64 | Divisor B, IEEE-754 double |
| out_valid | output | 1 | `cond` holds the result for the pair presented one cycle earlier |
| cond | output | 4 | Condition field {FL, FG, FE, 0} |

## Verification
FE and FG are produced side by side from the same classification. Several divisor classes raise both in the same cycle: a zero, an infinite or a denormal B, and an infinite A. Other classes raise only FE: a NaN on either side, or an exponent or difference at a limit. The directed cases mix these classes. Each result is judged as a full nibble, so a hint that is wrongly set or wrongly dropped, or a bit placed in the wrong position, shows up in that cycle. A second instance built without estimate precision confirms that FL changes on its own while FG and FE stay the same.

// File: rtl/div_screen_pkg.sv
package div_screen_pkg;

   // operand class flags, independent of operand width
   typedef struct packed {
      logic is_zero;
      logic is_denorm;
      logic is_inf;
      logic is_nan;
   } opclass_t;

   // bit positions inside the packed condition field
   localparam int unsigned COND_W   = 4;
   localparam int unsigned FL_POS   = 3;
   localparam int unsigned FG_POS   = 2;
   localparam int unsigned FE_POS   = 1;

endpackage

// File: rtl/dss_classify.sv
module dss_classify
   import div_screen_pkg::*;
#(
   parameter int unsigned EXP_W  = 11,
   parameter int unsigned FRAC_W = 52,
   localparam int unsigned OP_W  = EXP_W + FRAC_W + 1,
   localparam int unsigned SE_W  = EXP_W + 2
)(
   input  logic [OP_W-1:0]         op,
   output opclass_t                cls,
   output logic signed [SE_W-1:0]  unb_exp
);

   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam logic signed [SE_W-1:0] BIAS_S  = SE_W'(BIAS);
   localparam logic signed [SE_W-1:0] SUBN_E  = SE_W'(1 - BIAS);

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_max;
   logic              exp_min;
   logic              frac_nz;

   // sign bit (op[OP_W-1]) deliberately unused
   assign exp_f   = op[OP_W-2 -: EXP_W];
   assign frac_f  = op[FRAC_W-1:0];
   assign exp_max = &exp_f;
   assign exp_min = ~|exp_f;
   assign frac_nz = |frac_f;

   always_comb begin
      cls.is_nan    = exp_max &  frac_nz;
      cls.is_inf    = exp_max & ~frac_nz;
      cls.is_zero   = exp_min & ~frac_nz;
      cls.is_denorm = exp_min &  frac_nz;
   end

   always_comb begin
      if (exp_min)
         unb_exp = SUBN_E;
      else
         unb_exp = signed'({2'b00, exp_f}) - BIAS_S;
   end

endmodule

// File: rtl/dss_range_check.sv
module dss_range_check
   import div_screen_pkg::*;
#(
   parameter int unsigned EXP_W    = 11,
   parameter int          B_LO_LIM = -1022,
   parameter int          B_HI_LIM = 1021,
   parameter int          D_HI_LIM = 1023,
   parameter int          D_LO_LIM = -1021,
   parameter int          A_LO_LIM = -970,
   localparam int unsigned SE_W    = EXP_W + 2
)(
   input  opclass_t               a_cls,
   input  opclass_t               b_cls,
   input  logic signed [SE_W-1:0] a_exp,
   input  logic signed [SE_W-1:0] b_exp,
   output logic                   fe,
   output logic                   fg
);

   localparam logic signed [SE_W-1:0] T_B_LO = SE_W'(B_LO_LIM);
   localparam logic signed [SE_W-1:0] T_B_HI = SE_W'(B_HI_LIM);
   localparam logic signed [SE_W-1:0] T_D_HI = SE_W'(D_HI_LIM);
   localparam logic signed [SE_W-1:0] T_D_LO = SE_W'(D_LO_LIM);
   localparam logic signed [SE_W-1:0] T_A_LO = SE_W'(A_LO_LIM);

   logic signed [SE_W-1:0] diff;
   logic special_hit;
   logic b_range_hit;
   logic a_rel_hit;

   assign diff = a_exp - b_exp;

   assign special_hit = a_cls.is_nan | a_cls.is_inf |
                        b_cls.is_zero | b_cls.is_nan | b_cls.is_inf;

   assign b_range_hit = (b_exp <= T_B_LO) | (b_exp >= T_B_HI);

   assign a_rel_hit   = ~a_cls.is_zero &
                        ((diff >= T_D_HI) | (diff <= T_D_LO) | (a_exp <= T_A_LO));

   assign fe = special_hit | b_range_hit | a_rel_hit;
   assign fg = b_cls.is_zero | b_cls.is_inf | b_cls.is_denorm | a_cls.is_inf;

endmodule

// File: rtl/div_screen.sv
module div_screen
   import div_screen_pkg::*;
#(
   parameter int unsigned EXP_W       = 11,
   parameter int unsigned FRAC_W      = 52,
   parameter bit          EST_PRECISE = 1'b1,
   parameter int          B_LO_LIM    = -1022,
   parameter int          B_HI_LIM    = 1021,
   parameter int          D_HI_LIM    = 1023,
   parameter int          D_LO_LIM    = -1021,
   parameter int          A_LO_LIM    = -970,
   localparam int unsigned OP_W       = EXP_W + FRAC_W + 1,
   localparam int unsigned SE_W       = EXP_W + 2
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   opa,
   input  logic [OP_W-1:0]   opb,
   output logic              out_valid,
   output logic [COND_W-1:0] cond
);

   localparam int SE_MAX = (1 << (SE_W - 1)) - 1;
   localparam int SE_MIN = -(1 << (SE_W - 1));

   // elaboration-time parameter checks
   if (EXP_W < 2) begin : g_bad_exp
      $error("div_screen: EXP_W must be at least 2");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("div_screen: FRAC_W must be at least 1");
   end
   if (B_LO_LIM < SE_MIN || B_HI_LIM > SE_MAX || D_LO_LIM < SE_MIN ||
       D_HI_LIM > SE_MAX || A_LO_LIM < SE_MIN) begin : g_bad_lim
      $error("div_screen: a limit does not fit the signed exponent width");
   end

   opclass_t               cls   [2];
   logic signed [SE_W-1:0] ue    [2];
   logic [OP_W-1:0]        ops   [2];

   assign ops[0] = opa;
   assign ops[1] = opb;

   for (genvar gi = 0; gi < 2; gi++) begin : g_cls
      dss_classify #(
         .EXP_W  (EXP_W),
         .FRAC_W (FRAC_W)
      ) u_cls (
         .op      (ops[gi]),
         .cls     (cls[gi]),
         .unb_exp (ue[gi])
      );
   end

   logic fe_c;
   logic fg_c;
   logic fl_c;

   dss_range_check #(
      .EXP_W    (EXP_W),
      .B_LO_LIM (B_LO_LIM),
      .B_HI_LIM (B_HI_LIM),
      .D_HI_LIM (D_HI_LIM),
      .D_LO_LIM (D_LO_LIM),
      .A_LO_LIM (A_LO_LIM)
   ) u_rng (
      .a_cls (cls[0]),
      .b_cls (cls[1]),
      .a_exp (ue[0]),
      .b_exp (ue[1]),
      .fe    (fe_c),
      .fg    (fg_c)
   );

   if (EST_PRECISE) begin : g_fl_on
      assign fl_c = 1'b1;
   end else begin : g_fl_off
      assign fl_c = 1'b0;
   end

   logic [COND_W-1:0] cond_c;

   always_comb begin
      cond_c         = '0;
      cond_c[FL_POS] = fl_c;
      cond_c[FG_POS] = fg_c;
      cond_c[FE_POS] = fe_c;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         cond      <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            cond <= cond_c;
      end
   end

endmodule

// File: rtl/div_screen_chk.sv
module div_screen_chk
   import div_screen_pkg::*;
#(
   parameter int unsigned EXP_W       = 11,
   parameter int unsigned FRAC_W      = 52,
   parameter bit          EST_PRECISE = 1'b1,
   localparam int unsigned OP_W       = EXP_W + FRAC_W + 1
)(
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [OP_W-1:0]   opa,
   input logic [OP_W-1:0]   opb,
   input logic              out_valid,
   input logic [COND_W-1:0] cond
);

   logic a_inf_in;
   logic b_zero_in;
   logic b_nan_in;

   assign a_inf_in  = (&opa[OP_W-2 -: EXP_W]) & ~|opa[FRAC_W-1:0];
   assign b_zero_in = ~|opb[OP_W-2:0];
   assign b_nan_in  = (&opb[OP_W-2 -: EXP_W]) & |opb[FRAC_W-1:0];

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && cond == '0));

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R2
   valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R2
   cond_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(cond));

   // R3
   zero_div_fe_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && b_zero_in) |=> cond[FE_POS]);

   // R3
   nan_div_fe_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && b_nan_in) |=> cond[FE_POS]);

   // R7
   inf_num_fg_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && a_inf_in) |=> (cond[FG_POS] && cond[FE_POS]));

   // R8
   lsb_zero_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !cond[0]);

   // R8
   fl_param_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (cond[FL_POS] == EST_PRECISE));

endmodule

bind div_screen div_screen_chk #(
   .EXP_W       (EXP_W),
   .FRAC_W      (FRAC_W),
   .EST_PRECISE (EST_PRECISE)
) u_div_screen_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .opa       (opa),
   .opb       (opb),
   .out_valid (out_valid),
   .cond      (cond)
);

// File: tb/div_screen_bench.sv
module div_screen_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [63:0] opa = '0;
   logic [63:0] opb = '0;
   logic        out_valid;
   logic [3:0]  cond;
   logic        out_valid_nf;
   logic [3:0]  cond_nf;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   div_screen u_div_screen (
      .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
      .out_valid(out_valid), .cond(cond)
   );

   div_screen #(.EST_PRECISE(1'b0)) u_div_screen_nofl (
      .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
      .out_valid(out_valid_nf), .cond(cond_nf)
   );

   // operand with unbiased exponent e
   function automatic logic [63:0] fp(input bit s, input int e, input logic [51:0] f);
      int b;
      b = e + 1023;
      return {s, b[10:0], f};
   endfunction

   function automatic logic [63:0] raw(input bit s, input logic [10:0] ex, input logic [51:0] f);
      return {s, ex, f};
   endfunction

   localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
   localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
   localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
   localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
   localparam logic [63:0] PZERO = 64'h0000_0000_0000_0000;
   localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
   localparam logic [63:0] DENRM = 64'h0000_0000_0000_0001;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
      end
   endtask

   // present one pair, check result one edge later
   task automatic screen(input string tag, input logic [63:0] a, input logic [63:0] b,
                         input logic [3:0] exp);
      @(negedge clk);
      in_valid = 1'b1; opa = a; opb = b;
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " valid"}, 32'(out_valid), 32'd1);
      check(tag, 32'(cond), 32'(exp));
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 out_valid", 32'(out_valid), 32'd0);
      check("R1 cond", 32'(cond), 32'd0);
      rst = 1'b0;
   endtask

   task automatic t_specials;
      screen("R3 A qNaN",  QNAN, ONE, 4'hA);
      screen("R3 A sNaN",  SNAN, ONE, 4'hA);
      screen("R3 R7 A inf", PINF, ONE, 4'hE);
      screen("R3 R7 B +0", ONE, PZERO, 4'hE);
      screen("R3 R7 B -0", ONE, NZERO, 4'hE);
      screen("R3 R7 B inf", ONE, PINF, 4'hE);
      screen("R3 B qNaN",  ONE, QNAN, 4'hA);
      screen("R3 B sNaN",  ONE, SNAN, 4'hA);
   endtask

   task automatic t_b_range;
      screen("R4 eb=-1021", ONE, fp(0, -1021, 0), 4'h8);
      screen("R4 eb=-1022", ONE, fp(0, -1022, 0), 4'hA);
      screen("R4 eb=1020",  ONE, fp(0, 1020, 0), 4'h8);
      screen("R4 eb=1021",  ONE, fp(0, 1021, 0), 4'hA);
      screen("R4 R7 B denorm", ONE, DENRM, 4'hE);
   endtask

   task automatic t_diff;
      screen("R5 diff=1022",  fp(0, 1022, 0), ONE, 4'h8);
      screen("R5 diff=1023",  fp(0, 1023, 0), ONE, 4'hA);
      screen("R5 diff=-1020", ONE, fp(0, 1020, 0), 4'h8);
      screen("R5 diff=-1021", fp(0, -1, 0), fp(0, 1020, 0), 4'hA);
      screen("R5 A +0 ignores diff", PZERO, fp(0, 1020, 0), 4'h8);
      screen("R5 A -0 ignores diff", NZERO, ONE, 4'h8);
   endtask

   task automatic t_a_low;
      screen("R6 ea=-969", fp(0, -969, 0), ONE, 4'h8);
      screen("R6 ea=-970", fp(0, -970, 0), ONE, 4'hA);
      screen("R6 A denorm", raw(0, 11'd0, 52'h8_0000_0000_0000), ONE, 4'hA);
      screen("R6 plain normal", fp(0, 3, 52'h1234), fp(0, -5, 52'h55), 4'h8);
   endtask

   task automatic t_sign;
      screen("R9 negative pair", fp(1, 0, 0), fp(1, 0, 0), 4'h8);
      screen("R9 B -inf", ONE, raw(1, 11'h7FF, 52'h0), 4'hE);
      screen("R9 A -NaN", raw(1, 11'h7FF, 52'h1), fp(1, 2, 0), 4'hA);
   endtask

   task automatic t_stream;
      // back to back pairs, then an idle cycle
      @(negedge clk);
      in_valid = 1'b1; opa = ONE; opb = PZERO;
      @(negedge clk);
      check("R2 first of burst", 32'(cond), 32'hE);
      opa = ONE; opb = ONE;
      @(negedge clk);
      check("R2 second of burst", 32'(cond), 32'h8);
      check("R2 burst valid", 32'(out_valid), 32'd1);
      in_valid = 1'b0; opa = PINF; opb = PZERO;
      @(negedge clk);
      check("R2 idle valid", 32'(out_valid), 32'd0);
      check("R2 idle hold", 32'(cond), 32'h8);
   endtask

   task automatic t_fl;
      @(negedge clk);
      in_valid = 1'b1; opa = PINF; opb = ONE;
      @(negedge clk);
      in_valid = 1'b0;
      check("R8 no-FL variant", 32'(cond_nf), 32'h6);
      check("R8 FL variant", 32'(cond), 32'hE);
      screen("R8 field order", ONE, fp(0, 1021, 0), 4'hA);
      check("R8 no-FL normal", 32'(cond_nf), 32'h2);
   endtask

   task automatic t_reset_mid;
      @(negedge clk);
      in_valid = 1'b1; opa = ONE; opb = PZERO;
      rst = 1'b1;
      @(negedge clk);
      check("R1 mid reset valid", 32'(out_valid), 32'd0);
      check("R1 mid reset cond", 32'(cond), 32'd0);
      in_valid = 1'b0; rst = 1'b0;
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset;
      t_specials;
      t_b_range;
      t_diff;
      t_a_low;
      t_sign;
      t_stream;
      t_fl;
      t_reset_mid;
      repeat (2) @(negedge clk);
      finish_run;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: got=expired expected=done");
         finish_run;
      end
   end

endmodule